// File: doc/BRIEF.md
# I2C Slave Address Recognizer with General Call

This block is the address-recognition and status section of an I2C peripheral that works as a slave. A bit-level front end outside this block turns SCL/SDA into events: a START pulse, a STOP pulse, a byte-valid strobe with the received byte, and a busy level while a byte is being shifted. The first byte after a START is taken as the address byte. It matches when its upper seven bits equal the programmable own address. When general call is enabled, it also matches when its upper seven bits are all zero. The block is then selected for the rest of the transfer, and every later byte is stored until a STOP or a new START.

Both kinds of match raise the same addressed flag. The matching byte is kept in the data register, so software reads 0x00 there to spot a general call. A general call always leaves the block as a receiver. An arbitration-lost pulse from the master side sets a sticky flag. The addressed, transfer-complete and arbitration-lost flags feed one interrupt line, which is gated by an enable bit. In stop mode the block is frozen with its state kept. In wait mode a configuration bit chooses between two behaviours: the block keeps running, or it halts and drops the transfer in progress.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: After a START, a byte whose bits [7:1] equal ownAddr sets addrFlag and tcFlag, loads the byte into dataReg and loads bit 0 of the byte into srwFlag (1 = slave transmits). All outputs are registered, so they change one clock after the byte-valid cycle.
- R2: With the general call enable on, an address byte whose bits [7:1] are zero sets addrFlag and loads dataReg with the byte. srwFlag is cleared whatever bit 0 of the byte is.
- R3: With the general call enable off, an address byte of 0x00 does not match when ownAddr is nonzero. addrFlag stays clear and dataReg keeps its value.
- R4: Only the first byte after a START is compared as an address. Once the block is selected, each further byte loads dataReg and sets tcFlag. Bytes that arrive while the block is not selected, or with no START before them, change nothing.
- R5: addrFlag clears on a control write (ctrlWr) or on a STOP. A match in the same cycle as a control write sets the flag. A STOP in the same cycle as a match clears it.
- R6: tcFlag clears while shiftBusy is high. An accepted byte in the same cycle sets it.
- R7: An arbLost pulse sets alFlag, and alFlag stays set until a write to alClr. When the pulse and the clear come in the same cycle, the flag ends up set.
- R8: irq is high exactly when the interrupt enable is on and at least one of addrFlag, tcFlag or alFlag is set. The control word ctrlWdata uses bit 0 for interrupt enable, bit 1 for general call enable and bit 2 for halt-in-wait. All of them reset to 0.
- R9: While stopMode is high, START, STOP, byte, busy and arbLost inputs are ignored, and dataReg, srwFlag, tcFlag, addrFlag and alFlag keep their values.
- R10: With halt-in-wait set, waitMode high halts the block as in R9 and also ends the current selection, so bytes after waitMode falls are ignored until a new START. With halt-in-wait clear, the block runs normally in wait mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ownAddr | input | 7 | Own slave address |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlWdata | input | 3 | Control word: [0] irq enable, [1] general call enable, [2] halt in wait |
| alClr | input | 1 | Write-one clear of the arbitration-lost flag |
| startDet | input | 1 | START condition seen |
| stopDet | input | 1 | STOP condition seen |
| byteValid | input | 1 | A received byte is complete |
| rxByte | input | 8 | Received byte |
| shiftBusy | input | 1 | A byte is being shifted |
| arbLost | input | 1 | Arbitration-lost pulse |
| waitMode | input | 1 | Wait low-power mode |
| stopMode | input | 1 | Stop low-power mode |
| addrFlag | output | 1 | Addressed as slave |
| srwFlag | output | 1 | Slave direction, 1 = transmit |
| tcFlag | output | 1 | Transfer complete |
| alFlag | output | 1 | Arbitration lost |
| dataReg | output | 8 | Last accepted byte |
| irq | output | 1 | Merged interrupt |

## Verification
Several events can land on the same clock edge, and the bench drives them together on purpose. An arbLost pulse and an alClr write in one cycle must leave alFlag set. A matching address byte and a control write in one cycle must leave addrFlag set. A STOP in the same cycle as the last data byte must still clear addrFlag. The random phase makes these overlaps often, and every output is compared each cycle with a model built from the priority rules above. Directed steps also check the literal expected values of each of these overlaps.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic loadSrw;
  } dpStrobe_t;

  // Software-written configuration
  typedef struct packed {
    logic waitHalt;
    logic gcEn;
    logic intEn;
  } ctrlCfg_t;

  localparam int CTRL_W = $bits(ctrlCfg_t);
endpackage

// File: rtl/i2cam_datapath.sv
module i2cam_datapath
  import i2cam_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W:0]   rxByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEn,
  input  dpStrobe_t         strobe,
  output logic              ownHit,
  output logic              gcHit,
  output logic [ADDR_W:0]   dataReg,
  output logic              srwFlag
);
  localparam int BYTE_W = ADDR_W + 1;

  logic [ADDR_W-1:0] addrField;
  assign addrField = rxByte[BYTE_W-1:1];
  assign ownHit    = (addrField == ownAddr);
  assign gcHit     = gcEn && (addrField == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      srwFlag <= 1'b0;
    end else begin
      if (strobe.loadData) dataReg <= rxByte;
      // general call forces receive
      if (strobe.loadSrw) srwFlag <= gcHit ? 1'b0 : rxByte[0];
    end
  end
endmodule

// File: rtl/i2cam_control.sv
module i2cam_control
  import i2cam_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              alClr,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteValid,
  input  logic              shiftBusy,
  input  logic              arbLost,
  input  logic              waitMode,
  input  logic              stopMode,
  input  logic              ownHit,
  input  logic              gcHit,
  output logic              gcEn,
  output dpStrobe_t         strobe,
  output logic              addrFlag,
  output logic              tcFlag,
  output logic              alFlag,
  output logic              irq
);
  ctrlCfg_t cfg;
  logic awaitAddr, selected;
  logic waitHaltNow, active, addrByte, accept, dataByte;

  assign waitHaltNow = waitMode && cfg.waitHalt;
  assign active      = !stopMode && !waitHaltNow;
  assign addrByte    = active && byteValid && awaitAddr;
  assign accept      = addrByte && (ownHit || gcHit);
  assign dataByte    = active && byteValid && !awaitAddr && selected;

  assign strobe.loadData = accept || dataByte;
  assign strobe.loadSrw  = accept;
  assign gcEn = cfg.gcEn;
  assign irq  = cfg.intEn && (addrFlag || tcFlag || alFlag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg       <= '0;
      awaitAddr <= 1'b0;
      selected  <= 1'b0;
      addrFlag  <= 1'b0;
      tcFlag    <= 1'b0;
      alFlag    <= 1'b0;
    end else begin
      if (ctrlWr) cfg <= ctrlCfg_t'(ctrlWdata);

      // transfer session tracking
      if (waitHaltNow) begin
        awaitAddr <= 1'b0;
        selected  <= 1'b0;
      end else if (active) begin
        if (startDet) begin
          awaitAddr <= 1'b1;
          selected  <= 1'b0;
        end else if (stopDet) begin
          awaitAddr <= 1'b0;
          selected  <= 1'b0;
        end else if (addrByte) begin
          awaitAddr <= 1'b0;
          selected  <= accept;
        end
      end

      if (active && stopDet)  addrFlag <= 1'b0;
      else if (accept)        addrFlag <= 1'b1;
      else if (ctrlWr)        addrFlag <= 1'b0;

      if (accept || dataByte)       tcFlag <= 1'b1;
      else if (active && shiftBusy) tcFlag <= 1'b0;

      if (active && arbLost) alFlag <= 1'b1;
      else if (alClr)        alFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_slave_addr_match.sv
module i2c_slave_addr_match
  import i2cam_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              alClr,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteValid,
  input  logic [ADDR_W:0]   rxByte,
  input  logic              shiftBusy,
  input  logic              arbLost,
  input  logic              waitMode,
  input  logic              stopMode,
  output logic              addrFlag,
  output logic              srwFlag,
  output logic              tcFlag,
  output logic              alFlag,
  output logic [ADDR_W:0]   dataReg,
  output logic              irq
);
  dpStrobe_t strobe;
  logic ownHit, gcHit, gcEn;

  i2cam_control u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .alClr(alClr), .startDet(startDet), .stopDet(stopDet),
    .byteValid(byteValid), .shiftBusy(shiftBusy), .arbLost(arbLost),
    .waitMode(waitMode), .stopMode(stopMode), .ownHit(ownHit),
    .gcHit(gcHit), .gcEn(gcEn), .strobe(strobe), .addrFlag(addrFlag),
    .tcFlag(tcFlag), .alFlag(alFlag), .irq(irq)
  );

  i2cam_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .ownAddr(ownAddr),
    .gcEn(gcEn), .strobe(strobe), .ownHit(ownHit), .gcHit(gcHit),
    .dataReg(dataReg), .srwFlag(srwFlag)
  );
endmodule

// File: rtl/i2c_slave_addr_match_chk.sv
module i2c_slave_addr_match_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ownAddr,
  input logic              stopDet,
  input logic              byteValid,
  input logic              shiftBusy,
  input logic              arbLost,
  input logic              waitMode,
  input logic              stopMode,
  input logic              addrFlag,
  input logic              srwFlag,
  input logic              tcFlag,
  input logic              alFlag,
  input logic [ADDR_W:0]   dataReg,
  input logic              irq
);
  // R5
  stop_clears_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet && !stopMode && !waitMode |=> !addrFlag);

  // R7
  al_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost && !stopMode && !waitMode |=> alFlag);

  // R6
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftBusy && !byteValid && !stopMode && !waitMode |=> !tcFlag);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(addrFlag || tcFlag || alFlag) |-> !irq);

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> $stable(dataReg) && $stable(tcFlag) && $stable(srwFlag));

  // R2
  gc_receive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrFlag) && (dataReg[ADDR_W:1] == '0) && (ownAddr != '0) |-> !srwFlag);
endmodule

bind i2c_slave_addr_match i2c_slave_addr_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .stopDet(stopDet),
  .byteValid(byteValid), .shiftBusy(shiftBusy), .arbLost(arbLost),
  .waitMode(waitMode), .stopMode(stopMode), .addrFlag(addrFlag),
  .srwFlag(srwFlag), .tcFlag(tcFlag), .alFlag(alFlag), .dataReg(dataReg),
  .irq(irq)
);

// File: tb/sim_i2c_slave_addr_match.sv
module sim_i2c_slave_addr_match;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam logic [AW-1:0] OWN = 7'h3A;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, ctrlWr, alClr, startDet, stopDet, byteValid, shiftBusy;
  logic arbLost, waitMode, stopMode;
  logic [2:0] ctrlWdata;
  logic [AW:0] rxByte;
  logic [AW-1:0] ownAddr;
  logic addrFlag, srwFlag, tcFlag, alFlag, irq;
  logic [AW:0] dataReg;

  i2c_slave_addr_match #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .ctrlWr(ctrlWr),
    .ctrlWdata(ctrlWdata), .alClr(alClr), .startDet(startDet),
    .stopDet(stopDet), .byteValid(byteValid), .rxByte(rxByte),
    .shiftBusy(shiftBusy), .arbLost(arbLost), .waitMode(waitMode),
    .stopMode(stopMode), .addrFlag(addrFlag), .srwFlag(srwFlag),
    .tcFlag(tcFlag), .alFlag(alFlag), .dataReg(dataReg), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state, from the requirements
  logic mIntEn, mGcEn, mWaitHalt, mAwait, mSel, mAddr, mTc, mAl, mSrw;
  logic [AW:0] mData;

  function automatic logic isOwn(logic [AW:0] b);
    return b[AW:1] == ownAddr;
  endfunction
  function automatic logic isGc(logic [AW:0] b, logic en);
    return en && (b[AW:1] == '0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mIntEn, mGcEn, mWaitHalt, mAwait, mSel, mAddr, mTc, mAl, mSrw} <= '0;
      mData <= '0;
    end else begin
      logic halted, wh, ab, hit, db;
      wh = waitMode && mWaitHalt;
      halted = stopMode || wh;
      ab = !halted && byteValid && mAwait;
      hit = ab && (isOwn(rxByte) || isGc(rxByte, mGcEn));
      db = !halted && byteValid && !mAwait && mSel;
      if (ctrlWr) {mWaitHalt, mGcEn, mIntEn} <= ctrlWdata;
      if (wh) begin mAwait <= 0; mSel <= 0; end
      else if (!halted) begin
        if (startDet) begin mAwait <= 1; mSel <= 0; end
        else if (stopDet) begin mAwait <= 0; mSel <= 0; end
        else if (ab) begin mAwait <= 0; mSel <= hit; end
      end
      if (hit || db) mData <= rxByte;
      if (hit) mSrw <= isGc(rxByte, mGcEn) ? 1'b0 : rxByte[0];
      if (!halted && stopDet) mAddr <= 0;
      else if (hit) mAddr <= 1;
      else if (ctrlWr) mAddr <= 0;
      if (hit || db) mTc <= 1;
      else if (!halted && shiftBusy) mTc <= 0;
      if (!halted && arbLost) mAl <= 1;
      else if (alClr) mAl <= 0;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmpModel();
    chk("R1", "addrFlag", 32'(addrFlag), 32'(mAddr));
    chk("R1", "srwFlag", 32'(srwFlag), 32'(mSrw));
    chk("R4", "dataReg", 32'(dataReg), 32'(mData));
    chk("R6", "tcFlag", 32'(tcFlag), 32'(mTc));
    chk("R7", "alFlag", 32'(alFlag), 32'(mAl));
    chk("R8", "irq", 32'(irq), 32'(mIntEn && (mAddr || mTc || mAl)));
  endtask

  task automatic idle();
    {ctrlWr, alClr, startDet, stopDet, byteValid, shiftBusy, arbLost} = '0;
  endtask

  // apply current inputs for one edge, then sample at the following negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmpModel();
    idle();
  endtask

  task automatic wrCtrl(logic [2:0] v);
    ctrlWr = 1; ctrlWdata = v; tick();
  endtask
  task automatic sendStart();
    startDet = 1; tick();
  endtask
  task automatic sendStop();
    stopDet = 1; tick();
  endtask
  task automatic sendByte(logic [AW:0] b);
    byteValid = 1; rxByte = b; tick();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    ownAddr = OWN; ctrlWdata = '0; rxByte = '0;
    waitMode = 0; stopMode = 0; idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R8", "reset irq", 32'(irq), 0);
    chk("R1", "reset addrFlag", 32'(addrFlag), 0);
    chk("R4", "reset dataReg", 32'(dataReg), 0);

    wrCtrl(3'b011);
    // R1 own address, read direction
    sendStart(); sendByte({OWN, 1'b1});
    chk("R1", "own addr flag", 32'(addrFlag), 1);
    chk("R1", "own srw", 32'(srwFlag), 1);
    chk("R1", "own data", 32'(dataReg), 32'({OWN, 1'b1}));
    chk("R8", "irq on match", 32'(irq), 1);
    // R5 control write clears addrFlag
    wrCtrl(3'b011);
    chk("R5", "ctrl clears addr", 32'(addrFlag), 0);
    // R6 busy clears tc
    shiftBusy = 1; tick();
    chk("R6", "busy clears tc", 32'(tcFlag), 0);
    chk("R8", "irq off", 32'(irq), 0);
    // R6 busy and data byte together: set wins
    shiftBusy = 1; byteValid = 1; rxByte = 8'h5C; tick();
    chk("R6", "busy with byte", 32'(tcFlag), 1);
    chk("R4", "data byte stored", 32'(dataReg), 32'h5C);

    // R2 general call
    sendStart(); sendByte(8'h00);
    chk("R2", "gc flag", 32'(addrFlag), 1);
    chk("R2", "gc srw", 32'(srwFlag), 0);
    chk("R2", "gc data", 32'(dataReg), 0);
    sendByte(8'hA5);
    chk("R4", "gc first data byte", 32'(dataReg), 32'hA5);
    // R5 stop together with a data byte clears addrFlag
    stopDet = 1; byteValid = 1; rxByte = 8'h3C; tick();
    chk("R5", "stop clears addr", 32'(addrFlag), 0);
    chk("R4", "byte with stop stored", 32'(dataReg), 32'h3C);
    sendStart(); sendByte(8'h01);
    chk("R2", "gc rw1 flag", 32'(addrFlag), 1);
    chk("R2", "gc rw1 srw", 32'(srwFlag), 0);
    // R5 match and control write same cycle: set wins
    sendStop(); sendStart();
    ctrlWr = 1; ctrlWdata = 3'b011; byteValid = 1; rxByte = {OWN, 1'b0}; tick();
    chk("R5", "match beats ctrl write", 32'(addrFlag), 1);
    sendStop();

    // R3 general call disabled
    wrCtrl(3'b001);
    sendStart(); sendByte(8'h00);
    chk("R3", "gc off flag", 32'(addrFlag), 0);
    chk("R3", "gc off data", 32'(dataReg), 32'({OWN, 1'b0}));
    sendByte(8'h55);
    chk("R4", "unselected byte", 32'(dataReg), 32'({OWN, 1'b0}));
    // R4 byte with no START
    sendStop(); sendByte({OWN, 1'b0}); sendByte({OWN, 1'b1});
    chk("R4", "no start flag", 32'(addrFlag), 0);
    chk("R4", "no start data", 32'(dataReg), 32'({OWN, 1'b0}));

    // R7 arbitration lost
    arbLost = 1; alClr = 1; tick();
    chk("R7", "pulse beats clear", 32'(alFlag), 1);
    tick();
    chk("R7", "sticky", 32'(alFlag), 1);
    alClr = 1; tick();
    chk("R7", "cleared", 32'(alFlag), 0);
    arbLost = 1; tick();
    chk("R8", "irq on al", 32'(irq), 1);
    wrCtrl(3'b000);
    chk("R8", "irq gated", 32'(irq), 0);
    alClr = 1; tick();

    // R9 stop mode
    wrCtrl(3'b001);
    sendStart(); sendByte({OWN, 1'b1});
    stopMode = 1;
    stopDet = 1; byteValid = 1; rxByte = 8'h99; arbLost = 1; shiftBusy = 1; tick();
    chk("R9", "stop keeps addr", 32'(addrFlag), 1);
    chk("R9", "stop keeps data", 32'(dataReg), 32'({OWN, 1'b1}));
    chk("R9", "stop ignores al", 32'(alFlag), 0);
    chk("R9", "stop keeps tc", 32'(tcFlag), 1);
    stopMode = 0; tick();
    sendByte(8'h77);
    chk("R9", "session kept after stop", 32'(dataReg), 32'h77);

    // R10 halt in wait aborts the session
    wrCtrl(3'b101);
    waitMode = 1; tick();
    sendByte(8'h33);
    chk("R10", "wait halt ignores byte", 32'(dataReg), 32'h77);
    waitMode = 0; tick();
    sendByte(8'h44);
    chk("R10", "session aborted", 32'(dataReg), 32'h77);
    // R10 running in wait
    wrCtrl(3'b001);
    sendStart(); sendByte({OWN, 1'b0});
    waitMode = 1; tick();
    sendByte(8'h66);
    chk("R10", "wait runs", 32'(dataReg), 32'h66);
    waitMode = 0; sendStop();

    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 3);
      case (r)
        0: rxByte = {OWN, 1'($urandom_range(0, 1))};
        1: rxByte = 8'($urandom_range(0, 1));
        default: rxByte = 8'($urandom);
      endcase
      startDet  = ($urandom_range(0, 7) == 0);
      stopDet   = !startDet && ($urandom_range(0, 11) == 0);
      byteValid = ($urandom_range(0, 2) == 0);
      shiftBusy = ($urandom_range(0, 3) == 0);
      arbLost   = ($urandom_range(0, 15) == 0);
      alClr     = ($urandom_range(0, 9) == 0);
      ctrlWr    = ($urandom_range(0, 19) == 0);
      ctrlWdata = 3'($urandom);
      if ($urandom_range(0, 15) == 0) waitMode = !waitMode;
      stopMode  = ($urandom_range(0, 15) == 0);
      tick();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule